// File: doc/BRIEF.md
# Banked Stack Pointer Register File

This block holds the integer register state of a small processor core: thirteen 32-bit general-purpose registers (indices 0 to 12) and one stack-pointer index (13). Index 13 has two physical registers behind it, a main stack and a process stack. A stack-select bit and the current execution mode choose which one the index reaches. The block has two combinational read ports and one write port, each with a 4-bit index. Privilege and mode inputs come from the core. Any unprivileged attempt to reach the main stack is refused and reported on a one-cycle fault output.

Out of reset, a two-state controller fetches the initial main stack value from memory address zero through a request/valid handshake. While it waits, the block reports busy and refuses all register traffic. The controller has two states. BOOT_FETCH is entered on reset and raises the request. BOOT_RUN is normal operation. The only transition is BOOT_FETCH to BOOT_RUN, taken on the clock edge at which the fetch valid input is high. BOOT_RUN has only its self-loop and is left only through reset.

Top module: `bsp_regfile`

## Requirements
- R1: Indices 0 to 12 are 32-bit registers that reset to zero and can be read and written whatever the privilege input holds.
- R2: Read data follows the read index combinationally. A write lands on the rising clock edge, so a read of the index being written in the same cycle returns the old value.
- R3: In thread mode (`handler_i`=0), index 13 reaches the main stack when `sel_o`=0 and the process stack when `sel_o`=1. A write to index 13 is steered by the value `sel_o` holds before that edge.
- R4: In handler mode (`handler_i`=1), index 13 always reaches the main stack, whatever `sel_o` holds.
- R5: Bits 1:0 of any value stored into either stack register are cleared. This applies to register writes and to the boot load.
- R6: An access to the main stack with `priv_i`=0 has these effects: a write leaves the register unchanged, and a read returns zero. An access is a write, or a read with its enable high. Each cycle that holds such an access sets `fault_o` high for exactly the next cycle.
- R7: After reset, `fetch_req_o` and `busy_o` are high and `fetch_addr_o` is zero. On the edge where `fetch_valid_i` is high, the main stack takes `fetch_data_i`, and both `fetch_req_o` and `busy_o` fall.
- R8: While `busy_o` is high, both read ports return zero, and register writes and stack-select writes have no effect. `fault_o` is never raised while `busy_o` is high.
- R9: `sel_o` resets to 0. When `priv_i`=1, `sel_wr_en_i` loads it from `sel_wr_val_i` on the clock edge. When `priv_i`=0, that write is ignored.
- R10: Indices 14 and 15 read as zero, and writes to them change no register.
- R11: The process stack can be read and written with `priv_i`=0 or 1, and accessing it never raises `fault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | 1 = privileged level |
| handler_i | input | 1 | 1 = handler mode, 0 = thread mode |
| rd_a_en_i | input | 1 | Read port A access attempt |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_en_i | input | 1 | Read port B access attempt |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 32 | Write data |
| sel_wr_en_i | input | 1 | Stack-select write enable |
| sel_wr_val_i | input | 1 | Stack-select value to write |
| sel_o | output | 1 | Current stack-select bit |
| fetch_req_o | output | 1 | Boot fetch request |
| fetch_addr_o | output | 32 | Boot fetch address |
| fetch_valid_i | input | 1 | Boot fetch data valid |
| fetch_data_i | input | 32 | Boot fetch data |
| busy_o | output | 1 | Boot fetch in progress |
| fault_o | output | 1 | One-cycle access fault |

## Verification
The completion of the boot fetch can fall in the same cycle as an attempted write to the stack index. The bench provokes this by raising the fetch valid input in the same cycle that it drives a privileged write of a different value to index 13. It then judges that the main stack holds the aligned fetch data and that the write was dropped, because busy was still high at that edge. A second pairing is a read and a write to the same index in one cycle. The random phase raises this often, because its indices lean toward 13, and every read is compared with the model state from before the edge.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int XLEN_DEF = 32;
    localparam int NGPR_DEF = 13;
    localparam int IDXW_DEF = 4;

    typedef enum logic [0:0] {
        BOOT_FETCH = 1'b0,
        BOOT_RUN   = 1'b1
    } boot_state_e;

    typedef enum logic [1:0] {
        TGT_GPR  = 2'd0,
        TGT_MAIN = 2'd1,
        TGT_PROC = 2'd2,
        TGT_NONE = 2'd3
    } tgt_kind_e;
endpackage

// File: rtl/bsp_boot_fsm.sv
module bsp_boot_fsm
    import bsp_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid_i,
    output logic            fetch_req_o,
    output logic [XLEN-1:0] fetch_addr_o,
    output logic            busy_o,
    output logic            load_o
);
    boot_state_e state_q;

    // State register: the fetch state is left once the data arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BOOT_FETCH;
        end else begin
            unique case (state_q)
                BOOT_FETCH: if (fetch_valid_i) state_q <= BOOT_RUN;
                BOOT_RUN:   state_q <= BOOT_RUN;
                default:    state_q <= BOOT_FETCH;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fetch_req_o  = 1'b0;
        fetch_addr_o = '0;
        busy_o       = 1'b0;
        load_o       = 1'b0;
        unique case (state_q)
            BOOT_FETCH: begin
                fetch_req_o = 1'b1;
                busy_o      = 1'b1;
                load_o      = fetch_valid_i;
            end
            BOOT_RUN: begin
                busy_o = 1'b0;
            end
            default: begin
                busy_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bsp_route.sv
module bsp_route
    import bsp_pkg::*;
#(
    parameter int IDXW = IDXW_DEF,
    parameter int NGPR = NGPR_DEF
) (
    input  logic [IDXW-1:0] idx_i,
    input  logic            handler_i,
    input  logic            sel_i,
    input  logic            priv_i,
    output tgt_kind_e       kind_o,
    output logic            deny_o
);
    localparam logic [IDXW-1:0] SP_IDX  = IDXW'(NGPR);
    localparam logic [IDXW-1:0] GPR_LIM = IDXW'(NGPR);

    always_comb begin
        if (idx_i < GPR_LIM) begin
            kind_o = TGT_GPR;
        end else if (idx_i == SP_IDX) begin
            // handler mode pins the index to the main stack
            kind_o = (handler_i || !sel_i) ? TGT_MAIN : TGT_PROC;
        end else begin
            kind_o = TGT_NONE;
        end
        deny_o = (kind_o == TGT_MAIN) && !priv_i;
    end
endmodule

// File: rtl/bsp_gpr_bank.sv
module bsp_gpr_bank
    import bsp_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int NGPR = NGPR_DEF,
    parameter int IDXW = IDXW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [IDXW-1:0] ra_idx_i,
    input  logic [IDXW-1:0] rb_idx_i,
    output logic [XLEN-1:0] ra_data_o,
    output logic [XLEN-1:0] rb_data_o
);
    logic [XLEN-1:0] regs_q [NGPR];

    for (genvar g = 0; g < NGPR; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (we_i && (widx_i == IDXW'(g))) begin
                regs_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        ra_data_o = '0;
        rb_data_o = '0;
        for (int i = 0; i < NGPR; i++) begin
            if (ra_idx_i == IDXW'(i)) ra_data_o = regs_q[i];
            if (rb_idx_i == IDXW'(i)) rb_data_o = regs_q[i];
        end
    end
endmodule

// File: rtl/bsp_stack_bank.sv
module bsp_stack_bank
    import bsp_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_load_i,
    input  logic [XLEN-1:0] boot_data_i,
    input  logic            main_we_i,
    input  logic            proc_we_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] main_o,
    output logic [XLEN-1:0] proc_o
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    logic [XLEN-1:0] main_q, proc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            proc_q <= '0;
        end else begin
            if (boot_load_i) begin
                main_q <= boot_data_i & ALIGN_MASK;
            end else if (main_we_i) begin
                main_q <= wdata_i & ALIGN_MASK;
            end
            if (proc_we_i) begin
                proc_q <= wdata_i & ALIGN_MASK;
            end
        end
    end

    assign main_o = main_q;
    assign proc_o = proc_q;
endmodule

// File: rtl/bsp_regfile.sv
module bsp_regfile
    import bsp_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int NGPR = NGPR_DEF,
    parameter int IDXW = IDXW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            priv_i,
    input  logic            handler_i,
    input  logic            rd_a_en_i,
    input  logic [IDXW-1:0] rd_a_idx_i,
    output logic [XLEN-1:0] rd_a_data_o,
    input  logic            rd_b_en_i,
    input  logic [IDXW-1:0] rd_b_idx_i,
    output logic [XLEN-1:0] rd_b_data_o,
    input  logic            wr_en_i,
    input  logic [IDXW-1:0] wr_idx_i,
    input  logic [XLEN-1:0] wr_data_i,
    input  logic            sel_wr_en_i,
    input  logic            sel_wr_val_i,
    output logic            sel_o,
    output logic            fetch_req_o,
    output logic [XLEN-1:0] fetch_addr_o,
    input  logic            fetch_valid_i,
    input  logic [XLEN-1:0] fetch_data_i,
    output logic            busy_o,
    output logic            fault_o
);
    localparam int NPORT = 3;  // read A, read B, write

    logic            boot_load;
    logic            sel_q, fault_q;
    logic [XLEN-1:0] gpr_a, gpr_b, main_val, proc_val;
    logic [XLEN-1:0] port_rd [2];

    logic [IDXW-1:0] port_idx  [NPORT];
    tgt_kind_e       port_kind [NPORT];
    logic            port_deny [NPORT];
    logic            port_act  [NPORT];

    assign port_idx[0] = rd_a_idx_i;
    assign port_idx[1] = rd_b_idx_i;
    assign port_idx[2] = wr_idx_i;
    assign port_act[0] = rd_a_en_i;
    assign port_act[1] = rd_b_en_i;
    assign port_act[2] = wr_en_i;

    bsp_boot_fsm #(.XLEN(XLEN)) u_boot (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid_i (fetch_valid_i),
        .fetch_req_o   (fetch_req_o),
        .fetch_addr_o  (fetch_addr_o),
        .busy_o        (busy_o),
        .load_o        (boot_load)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_route
        bsp_route #(.IDXW(IDXW), .NGPR(NGPR)) u_route (
            .idx_i     (port_idx[p]),
            .handler_i (handler_i),
            .sel_i     (sel_q),
            .priv_i    (priv_i),
            .kind_o    (port_kind[p]),
            .deny_o    (port_deny[p])
        );
    end

    logic wr_ok;
    assign wr_ok = wr_en_i && !busy_o;

    bsp_gpr_bank #(.XLEN(XLEN), .NGPR(NGPR), .IDXW(IDXW)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_ok && (port_kind[2] == TGT_GPR)),
        .widx_i    (wr_idx_i),
        .wdata_i   (wr_data_i),
        .ra_idx_i  (rd_a_idx_i),
        .rb_idx_i  (rd_b_idx_i),
        .ra_data_o (gpr_a),
        .rb_data_o (gpr_b)
    );

    bsp_stack_bank #(.XLEN(XLEN)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_load_i (boot_load),
        .boot_data_i (fetch_data_i),
        .main_we_i   (wr_ok && (port_kind[2] == TGT_MAIN) && !port_deny[2]),
        .proc_we_i   (wr_ok && (port_kind[2] == TGT_PROC)),
        .wdata_i     (wr_data_i),
        .main_o      (main_val),
        .proc_o      (proc_val)
    );

    // Read multiplexers for both ports
    for (genvar r = 0; r < 2; r++) begin : g_read
        always_comb begin
            port_rd[r] = '0;
            if (!busy_o) begin
                unique case (port_kind[r])
                    TGT_GPR:  port_rd[r] = (r == 0) ? gpr_a : gpr_b;
                    TGT_MAIN: port_rd[r] = port_deny[r] ? '0 : main_val;
                    TGT_PROC: port_rd[r] = proc_val;
                    default:  port_rd[r] = '0;
                endcase
            end
        end
    end

    assign rd_a_data_o = port_rd[0];
    assign rd_b_data_o = port_rd[1];

    logic fault_d;
    always_comb begin
        fault_d = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (port_act[p] && port_deny[p]) fault_d = 1'b1;
        end
        fault_d = fault_d && !busy_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= fault_d;
            if (sel_wr_en_i && priv_i && !busy_o) begin
                sel_q <= sel_wr_val_i;
            end
        end
    end

    assign sel_o   = sel_q;
    assign fault_o = fault_q;
endmodule

// File: rtl/bsp_regfile_chk.sv
module bsp_regfile_chk #(
    parameter int XLEN   = 32,
    parameter int IDXW   = 4,
    parameter int SP_IDX = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            priv_i,
    input logic            rd_a_idx_valid_unused,
    input logic [IDXW-1:0] rd_a_idx_i,
    input logic [XLEN-1:0] rd_a_data_o,
    input logic [XLEN-1:0] rd_b_data_o,
    input logic            sel_wr_en_i,
    input logic            sel_o,
    input logic            fetch_req_o,
    input logic [XLEN-1:0] fetch_addr_o,
    input logic            fetch_valid_i,
    input logic            busy_o,
    input logic            fault_o
);
    // R7: the request always points at address zero
    p_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> (fetch_addr_o == '0));

    // R7: busy only drops after fetch data was presented
    p_busy_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(fetch_valid_i));

    // R8: nothing is read while busy
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rd_a_data_o == '0 && rd_b_data_o == '0));

    // R8: no fault can follow a busy cycle
    p_no_fault_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> !fault_o);

    // R6: a fault is only raised after an unprivileged cycle
    p_fault_unpriv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(!priv_i));

    // R9: the stack-select bit changes only by a privileged write
    p_sel_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_o) |-> $past(priv_i && sel_wr_en_i && !busy_o));

    // R5: any stack value read out is word aligned
    p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == IDXW'(SP_IDX)) |-> (rd_a_data_o[1:0] == 2'b00));
endmodule

bind bsp_regfile bsp_regfile_chk #(.XLEN(XLEN), .IDXW(IDXW), .SP_IDX(NGPR)) u_chk (
    .clk                   (clk),
    .rst_n                 (rst_n),
    .priv_i                (priv_i),
    .rd_a_idx_valid_unused (rd_a_en_i),
    .rd_a_idx_i            (rd_a_idx_i),
    .rd_a_data_o           (rd_a_data_o),
    .rd_b_data_o           (rd_b_data_o),
    .sel_wr_en_i           (sel_wr_en_i),
    .sel_o                 (sel_o),
    .fetch_req_o           (fetch_req_o),
    .fetch_addr_o          (fetch_addr_o),
    .fetch_valid_i         (fetch_valid_i),
    .busy_o                (busy_o),
    .fault_o               (fault_o)
);

// File: tb/sim_bsp_regfile.sv
module sim_bsp_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int IDXW = 4;
    localparam int NGPR = 13;
    localparam int N_RANDOM = 4000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            priv_i, handler_i;
    logic            rd_a_en_i, rd_b_en_i, wr_en_i;
    logic [IDXW-1:0] rd_a_idx_i, rd_b_idx_i, wr_idx_i;
    logic [XLEN-1:0] rd_a_data_o, rd_b_data_o, wr_data_i;
    logic            sel_wr_en_i, sel_wr_val_i, sel_o;
    logic            fetch_req_o, fetch_valid_i, busy_o, fault_o;
    logic [XLEN-1:0] fetch_addr_o, fetch_data_i;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsp_regfile #(.XLEN(XLEN), .NGPR(NGPR), .IDXW(IDXW)) u0 (
        .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .handler_i(handler_i),
        .rd_a_en_i(rd_a_en_i), .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
        .rd_b_en_i(rd_b_en_i), .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .sel_wr_en_i(sel_wr_en_i), .sel_wr_val_i(sel_wr_val_i), .sel_o(sel_o),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i),
        .busy_o(busy_o), .fault_o(fault_o)
    );

    // Reference model state
    logic [XLEN-1:0] m_gpr [NGPR];
    logic [XLEN-1:0] m_main, m_proc;
    logic            m_sel, m_busy, exp_fault;
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // 0..12 gpr, 13 main, 14 process, 15 none
    function automatic int resolve(logic [IDXW-1:0] idx);
        if (idx < NGPR) return int'(idx);
        if (idx == NGPR) return (handler_i || !m_sel) ? 13 : 14;
        return 15;
    endfunction

    function automatic logic [XLEN-1:0] exp_read(logic [IDXW-1:0] idx);
        int t = resolve(idx);
        if (m_busy) return '0;
        if (t < NGPR) return m_gpr[t];
        if (t == 13) return priv_i ? m_main : '0;
        if (t == 14) return m_proc;
        return '0;
    endfunction

    // Inputs are set at a negedge; this checks reads, clocks once, updates the model
    task automatic step();
        int tw;
        logic f;
        #1;
        chk("R2/R3/R4/R6/R8/R10 read A", rd_a_data_o, exp_read(rd_a_idx_i));
        chk("R2/R3/R4/R6/R8/R10 read B", rd_b_data_o, exp_read(rd_b_idx_i));
        tw = resolve(wr_idx_i);
        f = !m_busy && !priv_i &&
            ((rd_a_en_i && resolve(rd_a_idx_i) == 13) ||
             (rd_b_en_i && resolve(rd_b_idx_i) == 13) ||
             (wr_en_i && tw == 13));
        @(posedge clk);
        if (m_busy) begin
            if (fetch_valid_i) begin
                m_main = fetch_data_i & ~32'd3;
                m_busy = 1'b0;
            end
        end else begin
            if (wr_en_i) begin
                if (tw < NGPR) m_gpr[tw] = wr_data_i;
                else if (tw == 13 && priv_i) m_main = wr_data_i & ~32'd3;
                else if (tw == 14) m_proc = wr_data_i & ~32'd3;
            end
            if (sel_wr_en_i && priv_i) m_sel = sel_wr_val_i;
        end
        exp_fault = f;
        @(negedge clk);
        chk("R6/R8/R11 fault", {31'd0, fault_o}, {31'd0, exp_fault});
        chk("R9 sel", {31'd0, sel_o}, {31'd0, m_sel});
        chk("R7 busy", {31'd0, busy_o}, {31'd0, m_busy});
        chk("R7 request", {31'd0, fetch_req_o}, {31'd0, m_busy});
    endtask

    task automatic idle();
        rd_a_en_i = 0; rd_b_en_i = 0; wr_en_i = 0; sel_wr_en_i = 0;
        fetch_valid_i = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        rst_n = 0; priv_i = 1; handler_i = 0;
        rd_a_idx_i = 0; rd_b_idx_i = 0; wr_idx_i = 0; wr_data_i = 0;
        sel_wr_val_i = 0; fetch_data_i = 0;
        idle();
        for (int i = 0; i < NGPR; i++) m_gpr[i] = '0;
        m_main = '0; m_proc = '0; m_sel = 0; m_busy = 1; exp_fault = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state
        chk("R7 reset busy", {31'd0, busy_o}, 32'd1);
        chk("R7 reset request", {31'd0, fetch_req_o}, 32'd1);
        chk("R7 reset address", fetch_addr_o, 32'd0);
        chk("R9 reset sel", {31'd0, sel_o}, 32'd0);
        chk("R6 reset fault", {31'd0, fault_o}, 32'd0);
        rst_n = 1;

        // R8: traffic while busy is dropped
        wr_en_i = 1; wr_idx_i = 4'd1; wr_data_i = 32'hDEAD_BEEF;
        rd_a_en_i = 1; rd_a_idx_i = 4'd13; priv_i = 0;
        sel_wr_en_i = 1; sel_wr_val_i = 1;
        step();
        chk("R7 address while busy", fetch_addr_o, 32'd0);
        priv_i = 1;
        step();
        // R7: fetch completes in the same cycle as a stack write attempt
        idle();
        fetch_valid_i = 1; fetch_data_i = 32'h2000_0007;
        wr_en_i = 1; wr_idx_i = 4'd13; wr_data_i = 32'h1111_1110;
        step();
        idle();
        rd_a_idx_i = 4'd13; rd_b_idx_i = 4'd1;
        #1;
        chk("R5/R7 boot value", rd_a_data_o, 32'h2000_0004);
        chk("R1/R8 write while busy dropped", rd_b_data_o, 32'd0);

        // R2: read and write of one index in one cycle returns old
        rd_a_idx_i = 4'd5; wr_en_i = 1; wr_idx_i = 4'd5; wr_data_i = 32'hCAFE_0001;
        step();
        idle(); rd_a_idx_i = 4'd5; #1;
        chk("R2 new value after edge", rd_a_data_o, 32'hCAFE_0001);

        // R3/R5: thread, sel=0 write goes to main, aligned
        wr_en_i = 1; wr_idx_i = 4'd13; wr_data_i = 32'h1234_567B;
        step();
        idle(); sel_wr_en_i = 1; sel_wr_val_i = 1; step();
        idle(); wr_en_i = 1; wr_idx_i = 4'd13; wr_data_i = 32'h0000_8003; step();
        // R11: unprivileged process access, no fault
        idle(); priv_i = 0; rd_a_en_i = 1; rd_a_idx_i = 4'd13; step();
        chk("R11 no fault on process read", {31'd0, fault_o}, 32'd0);
        // R4/R6: handler unprivileged reaches main, refused
        handler_i = 1; wr_en_i = 1; wr_idx_i = 4'd13; wr_data_i = 32'hFFFF_FFFF; step();
        chk("R6 fault pulse", {31'd0, fault_o}, 32'd1);
        idle(); step();
        chk("R6 fault single cycle", {31'd0, fault_o}, 32'd0);
        priv_i = 1; rd_a_idx_i = 4'd13; #1;
        chk("R4/R6 main unchanged", rd_a_data_o, 32'h1234_5678);
        handler_i = 0; #1;
        chk("R3 thread sel=1 process", rd_a_data_o, 32'h0000_8000);
        // R9: unprivileged select write ignored
        priv_i = 0; sel_wr_en_i = 1; sel_wr_val_i = 0; step();
        chk("R9 unprivileged sel write ignored", {31'd0, sel_o}, 32'd1);
        // R10: index 14/15
        idle(); priv_i = 1; wr_en_i = 1; wr_idx_i = 4'd15; wr_data_i = 32'h5555_5555;
        rd_a_idx_i = 4'd14; step();

        // Random phase
        for (int n = 0; n < N_RANDOM; n++) begin
            priv_i       = ($urandom % 3) != 0;
            handler_i    = ($urandom % 4) == 0;
            rd_a_en_i    = $urandom % 2;
            rd_b_en_i    = $urandom % 2;
            wr_en_i      = $urandom % 2;
            rd_a_idx_i   = ($urandom % 3 == 0) ? 4'd13 : IDXW'($urandom % 16);
            rd_b_idx_i   = ($urandom % 3 == 0) ? 4'd13 : IDXW'($urandom % 16);
            wr_idx_i     = ($urandom % 3 == 0) ? 4'd13 : IDXW'($urandom % 16);
            wr_data_i    = $urandom;
            sel_wr_en_i  = ($urandom % 8) == 0;
            sel_wr_val_i = $urandom % 2;
            if ($urandom % 4 == 0) rd_a_idx_i = wr_idx_i;
            step();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule